// File: doc/BRIEF.md
# Address-Folding SECDED Checker for Program Flash Reads

This block sits on the read path between a program-flash array and the processor. Each read delivers one 64-bit word, the byte address it came from, and the 8-bit check byte held for that word. The block rebuilds the check byte from the data and from the doubleword part of the address. It then compares the result with the stored byte. A single flipped bit is repaired in the returned data. A multi-bit fault is reported and the data passes through unmodified. Because address bits go into the code, a word read back from the wrong doubleword location is caught like any other fault. A blank word (all ones with an all-ones check byte) is always reported as uncorrectable.

An enable input carries the flash-ECC enable bit (bit 25) of the processor's auxiliary control word. While it is clear, words pass through unchecked. The block also returns the location of each word's check byte, which is a fixed check-region base plus the word address shifted right by three. A capture register keeps the address of the first uncorrectable read until software clears it.

Top module: `flash_ecc_chk`

## Requirements
- R1: The information vector is {addr[31:3], data[63:0]}, with data bit j at index j and address bit 3+i at index 64+i. Information index j gets column value n_j, the j-th integer (from 0) in 3..127 that is not a power of two. Check bit k (k = 0..6) is the XOR of all information bits whose column has bit k set. Bit 7 is the XOR of every information bit and check bits 6:0. The stored byte is this value XOR 0x0C.
- R2: A word whose check byte matches R1 returns its data unchanged, with out_sec and out_ded both low.
- R3: A word with exactly one data bit inverted relative to its R1 code returns the original data and raises out_sec.
- R4: A word with exactly one check-byte bit inverted (any of bits 0..7) returns the data unchanged and raises out_sec.
- R5: A word encoded at one address and read at an address that differs in exactly one of bits 31:3 returns the data unchanged and raises out_sec. A difference only in bits 2:0 is ignored, so the word reads as clean.
- R6: A word with two inverted bits (two data bits, or one data bit and one check bit) raises out_ded, leaves out_sec low, and returns the received data unmodified.
- R7: Data of all ones with check byte 0xFF raises out_ded at every address.
- R8: A check byte computed under R1 but without the 0x0C inversion raises out_ded.
- R9: When ecc_en is low at the input cycle, out_data equals in_data, both flags stay low, and the capture register is not loaded.
- R10: out_vld rises exactly two clock edges after an edge that samples in_vld high. out_sec and out_ded are low whenever out_vld is low.
- R11: With out_vld, out_chk_addr equals CHK_BASE + (in_addr >> 3) for the same word, with CHK_BASE defaulting to 0xF0400000.
- R12: The first uncorrectable word sets fail_vld and loads its full address into fail_addr. Both then hold until fail_clr, which clears them to zero and wins over a capture in the same cycle.
- R13: out_sec and out_ded are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Flash-ECC enable bit of the core control word |
| in_vld | input | 1 | Read word present |
| in_addr | input | 32 | Byte address of the word |
| in_data | input | 64 | Data word from flash |
| in_chk | input | 8 | Stored check byte for the word |
| fail_clr | input | 1 | Clears the uncorrectable-address capture |
| out_vld | output | 1 | Result present |
| out_data | output | 64 | Corrected or passed-through data |
| out_sec | output | 1 | Single error found and handled |
| out_ded | output | 1 | Uncorrectable error |
| out_chk_addr | output | 32 | Location of the word's check byte |
| fail_vld | output | 1 | Capture register holds an address |
| fail_addr | output | 32 | Address of the first uncorrectable read |

## Verification
The hardest case to reach from the ports is a single fault in an address-derived term. No bit of the received word is wrong; only the location differs. The bench encodes a word for one address and presents it at each address that differs in one bit, then checks for correction without any change to the data. Blank words are swept over hundreds of addresses. This shows the uncorrectable report does not depend on how the address bits happen to fold into the syndrome.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;

  localparam int DATA_W    = 64;
  localparam int ADDR_W    = 32;
  localparam int ALIGN_LSB = 3;
  localparam int AHI_W     = ADDR_W - ALIGN_LSB;
  localparam int INFO_W    = DATA_W + AHI_W;
  localparam int HAM_W     = 7;
  localparam int CODE_W    = HAM_W + 1;
  localparam logic [CODE_W-1:0] POL_MASK = 8'h0C;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_MULTI  = 2'd2
  } ecc_cls_e;

  // Column of information bit idx: idx-th non power of two from 3 upward
  function automatic logic [HAM_W-1:0] col_of(input int idx);
    int seen;
    logic [HAM_W-1:0] res;
    seen = 0;
    res  = '0;
    for (int n = 3; n < (1 << HAM_W); n++) begin
      if ((n & (n - 1)) != 0) begin
        if (seen == idx) res = HAM_W'(n);
        seen++;
      end
    end
    return res;
  endfunction

  // Information bits feeding Hamming check bit k
  function automatic logic [INFO_W-1:0] row_mask(input int k);
    logic [INFO_W-1:0] m;
    logic [HAM_W-1:0]  c;
    m = '0;
    for (int j = 0; j < INFO_W; j++) begin
      c    = col_of(j);
      m[j] = c[k];
    end
    return m;
  endfunction

endpackage

// File: rtl/fecc_syndrome.sv
module fecc_syndrome
  import flash_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [AHI_W-1:0]  ahi_i,
  output logic [HAM_W-1:0]  ham_o,
  output logic              info_par_o
);

  logic [INFO_W-1:0] info;
  assign info = {ahi_i, data_i};

  for (genvar k = 0; k < HAM_W; k++) begin : g_row
    localparam logic [INFO_W-1:0] ROW = row_mask(k);
    assign ham_o[k] = ^(info & ROW);
  end

  assign info_par_o = ^info;

endmodule

// File: rtl/fecc_classify.sv
module fecc_classify
  import flash_ecc_pkg::*;
(
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CODE_W-1:0] chk_i,
  input  logic [HAM_W-1:0]  ham_i,
  input  logic              info_par_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);

  logic [CODE_W-1:0] rx_n;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              is_pow;
  logic              known;
  logic              blank;
  logic [INFO_W-1:0] hit;
  ecc_cls_e          cls;

  assign rx_n = chk_i ^ POL_MASK;
  assign syn  = ham_i ^ rx_n[HAM_W-1:0];
  assign odd  = info_par_i ^ (^rx_n);

  for (genvar j = 0; j < INFO_W; j++) begin : g_col
    localparam logic [HAM_W-1:0] COL = col_of(j);
    assign hit[j] = (syn == COL);
  end

  assign is_pow = (syn != '0) && ((syn & (syn - HAM_W'(1))) == '0);
  assign known  = (syn == '0) || is_pow || (|hit);
  assign blank  = (&data_i) && (&chk_i);

  always_comb begin
    if (blank)      cls = CLS_MULTI;
    else if (!odd)  cls = (syn == '0) ? CLS_CLEAN : CLS_MULTI;
    else if (known) cls = CLS_SINGLE;
    else            cls = CLS_MULTI;
  end

  assign sec_o  = en_i && (cls == CLS_SINGLE);
  assign ded_o  = en_i && (cls == CLS_MULTI);
  assign data_o = data_i ^ (sec_o ? hit[DATA_W-1:0] : '0);

endmodule

// File: rtl/fecc_chk_loc.sv
module fecc_chk_loc
  import flash_ecc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHK_BASE = 32'hF040_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] loc_o
);

  assign loc_o = CHK_BASE + (addr_i >> ALIGN_LSB);

endmodule

// File: rtl/flash_ecc_chk.sv
module flash_ecc_chk
  import flash_ecc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHK_BASE = 32'hF040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_en,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CODE_W-1:0] in_chk,
  input  logic              fail_clr,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sec,
  output logic              out_ded,
  output logic [ADDR_W-1:0] out_chk_addr,
  output logic              fail_vld,
  output logic [ADDR_W-1:0] fail_addr
);

  // input stage
  logic              s1_vld;
  logic              s1_en;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;
  logic [CODE_W-1:0] s1_chk;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_en  <= 1'b0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) s1_en <= ecc_en;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      s1_addr <= in_addr;
      s1_data <= in_data;
      s1_chk  <= in_chk;
    end
  end

  // decode
  logic [HAM_W-1:0]  ham;
  logic              info_par;
  logic [DATA_W-1:0] fix_data;
  logic              sec;
  logic              ded;
  logic [ADDR_W-1:0] loc;

  fecc_syndrome u_syn (
    .data_i     (s1_data),
    .ahi_i      (s1_addr[ADDR_W-1:ALIGN_LSB]),
    .ham_o      (ham),
    .info_par_o (info_par)
  );

  fecc_classify u_cls (
    .en_i       (s1_en),
    .data_i     (s1_data),
    .chk_i      (s1_chk),
    .ham_i      (ham),
    .info_par_i (info_par),
    .data_o     (fix_data),
    .sec_o      (sec),
    .ded_o      (ded)
  );

  fecc_chk_loc #(.CHK_BASE(CHK_BASE)) u_loc (
    .addr_i (s1_addr),
    .loc_o  (loc)
  );

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_sec <= 1'b0;
      out_ded <= 1'b0;
    end else begin
      out_vld <= s1_vld;
      out_sec <= s1_vld && sec;
      out_ded <= s1_vld && ded;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      out_data     <= fix_data;
      out_chk_addr <= loc;
    end
  end

  // first uncorrectable address capture
  always_ff @(posedge clk) begin
    if (rst || fail_clr) begin
      fail_vld  <= 1'b0;
      fail_addr <= '0;
    end else if (s1_vld && ded && !fail_vld) begin
      fail_vld  <= 1'b1;
      fail_addr <= s1_addr;
    end
  end

endmodule

// File: rtl/flash_ecc_chk_sva.sv
module flash_ecc_chk_sva
  import flash_ecc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHK_BASE = 32'hF040_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              ecc_en,
  input logic              in_vld,
  input logic [ADDR_W-1:0] in_addr,
  input logic [DATA_W-1:0] in_data,
  input logic [CODE_W-1:0] in_chk,
  input logic              fail_clr,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sec,
  input logic              out_ded,
  input logic [ADDR_W-1:0] out_chk_addr,
  input logic              fail_vld,
  input logic [ADDR_W-1:0] fail_addr
);

  // R13
  sec_ded_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_sec && out_ded));

  // R10
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 out_vld);

  // R10
  flag_qual_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (!out_sec && !out_ded));

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !ecc_en) |=> ##1 (!out_sec && !out_ded && out_data == $past(in_data, 2)));

  // R6
  ded_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 (out_ded |-> out_data == $past(in_data, 2)));

  // R11
  chk_loc_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 (out_chk_addr == $past(CHK_BASE + (in_addr >> ALIGN_LSB), 2)));

  // R12
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_vld && !fail_clr) |=> (fail_vld && $stable(fail_addr)));

  // R12
  fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fail_clr |=> (!fail_vld && fail_addr == '0));

  // R12
  fail_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_vld) |-> (out_ded && out_vld));

  logic unused_ok;
  assign unused_ok = ^in_chk;

endmodule

bind flash_ecc_chk flash_ecc_chk_sva #(.CHK_BASE(CHK_BASE)) u_sva (.*);

// File: tb/flash_ecc_chk_bench.sv
`timescale 1ns/1ps
module flash_ecc_chk_bench;

  localparam logic [31:0] BASE = 32'hF040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ecc_en = 1'b0;
  logic        in_vld = 1'b0;
  logic [31:0] in_addr = '0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_chk = '0;
  logic        fail_clr = 1'b0;
  logic        out_vld;
  logic [63:0] out_data;
  logic        out_sec;
  logic        out_ded;
  logic [31:0] out_chk_addr;
  logic        fail_vld;
  logic [31:0] fail_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_ecc_chk #(.CHK_BASE(BASE)) u_flash_ecc_chk (
    .clk(clk), .rst(rst), .ecc_en(ecc_en), .in_vld(in_vld),
    .in_addr(in_addr), .in_data(in_data), .in_chk(in_chk),
    .fail_clr(fail_clr), .out_vld(out_vld), .out_data(out_data),
    .out_sec(out_sec), .out_ded(out_ded), .out_chk_addr(out_chk_addr),
    .fail_vld(fail_vld), .fail_addr(fail_addr)
  );

  // R1: check byte from the column rule
  function automatic logic [7:0] enc(input logic [63:0] d, input logic [31:0] a);
    logic [92:0] info;
    logic [6:0]  h;
    int          j;
    info = {a[31:3], d};
    h = '0;
    j = 0;
    for (int n = 3; n < 128; n++) begin
      if ((n & (n - 1)) != 0) begin
        if (j < 93) begin
          if (info[j]) h ^= 7'(n);
        end
        j++;
      end
    end
    return {(^info) ^ (^h), h} ^ 8'h0C;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic en, input logic [31:0] a, input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    ecc_en = en; in_addr = a; in_data = d; in_chk = c; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [63:0] d, input logic s, input logic e);
    check(req, {61'd0, out_vld, out_sec, out_ded, out_data}, {61'd0, 1'b1, s, e, d});
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    fail_clr = 1'b1;
    @(negedge clk);
    fail_clr = 1'b0;
  endtask

  logic [31:0] addrs [6];
  logic [63:0] pats  [6];

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    addrs[0] = 32'h0000_0000; addrs[1] = 32'h0001_F800; addrs[2] = 32'h0001_9B00;
    addrs[3] = 32'hFFFF_FFF8; addrs[4] = 32'h1234_5670; addrs[5] = 32'h8000_0008;
    pats[0] = 64'h0; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF; pats[2] = 64'hDEAD_BEEF_0123_4567;
    pats[3] = 64'h5555_AAAA_0F0F_F0F0; pats[4] = 64'h0000_0001_8000_0000; pats[5] = 64'hFFFF_FFFF_FFFF_FF8F;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R10, R12)
    check("R10 reset", {125'd0, out_vld, out_sec, out_ded}, 128'd0);
    check("R12 reset", {95'd0, fail_vld, fail_addr}, 128'd0);

    // R2, R11: clean words
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 6; k++) begin
        xfer(1'b1, addrs[i], pats[k], enc(pats[k], addrs[i]));
        expect_out("R2 clean", pats[k], 1'b0, 1'b0);
        check("R11 loc", {96'd0, out_chk_addr}, {96'd0, BASE + (addrs[i] >> 3)});
      end
    end

    // R3: every single data bit
    for (int i = 0; i < 3; i++) begin
      for (int b = 0; b < 64; b++) begin
        xfer(1'b1, addrs[i], pats[i + 2] ^ (64'd1 << b), enc(pats[i + 2], addrs[i]));
        expect_out("R3 data single", pats[i + 2], 1'b1, 1'b0);
      end
    end

    // R4: every check bit
    for (int i = 0; i < 6; i++) begin
      for (int b = 0; b < 8; b++) begin
        xfer(1'b1, addrs[i], pats[i], enc(pats[i], addrs[i]) ^ (8'd1 << b));
        expect_out("R4 check single", pats[i], 1'b1, 1'b0);
      end
    end

    // R5: address term single and ignored low bits
    for (int i = 0; i < 2; i++) begin
      for (int b = 3; b < 32; b++) begin
        xfer(1'b1, addrs[i + 1] ^ (32'd1 << b), pats[i + 2], enc(pats[i + 2], addrs[i + 1]));
        expect_out("R5 addr single", pats[i + 2], 1'b1, 1'b0);
      end
      for (int b = 0; b < 3; b++) begin
        xfer(1'b1, addrs[i + 1] ^ (32'd1 << b), pats[i + 2], enc(pats[i + 2], addrs[i + 1]));
        expect_out("R5 low bits ignored", pats[i + 2], 1'b0, 1'b0);
      end
    end

    // R6: double faults pass through
    for (int b = 0; b < 64; b++) begin
      logic [63:0] d2;
      d2 = pats[3] ^ (64'd1 << b) ^ (64'd1 << ((b + 1 + (b % 7)) % 64));
      xfer(1'b1, addrs[4], d2, enc(pats[3], addrs[4]));
      expect_out("R6 data double", d2, 1'b0, 1'b1);
      xfer(1'b1, addrs[2], pats[2] ^ (64'd1 << b), enc(pats[2], addrs[2]) ^ (8'd1 << (b % 8)));
      expect_out("R6 data+check double", pats[2] ^ (64'd1 << b), 1'b0, 1'b1);
    end

    // R8: missing polarity inversion
    for (int i = 0; i < 6; i++) begin
      xfer(1'b1, addrs[i], pats[i], enc(pats[i], addrs[i]) ^ 8'h0C);
      expect_out("R8 polarity", pats[i], 1'b0, 1'b1);
    end

    // R7: blank words everywhere
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = (i < 300) ? (32'(i) << 3) : (32'(i) * 32'h0009_E3B8) ^ 32'h0001_F800;
      xfer(1'b1, a, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
      expect_out("R7 blank", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    end

    // R12: capture the first failing address
    pulse_clr();
    check("R12 clear", {95'd0, fail_vld, fail_addr}, 128'd0);
    // R9: disabled path, corrupted and blank words
    xfer(1'b0, 32'h0001_9B04, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    expect_out("R9 off blank", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    xfer(1'b0, addrs[2], pats[2] ^ 64'h3, enc(pats[2], addrs[2]));
    expect_out("R9 off double", pats[2] ^ 64'h3, 1'b0, 1'b0);
    xfer(1'b0, addrs[3], pats[3] ^ 64'h10, enc(pats[3], addrs[3]));
    expect_out("R9 off single", pats[3] ^ 64'h10, 1'b0, 1'b0);
    check("R9 no capture", {95'd0, fail_vld, fail_addr}, 128'd0);

    xfer(1'b1, 32'h0001_9B04, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    check("R12 first capture", {95'd0, fail_vld, fail_addr}, {95'd0, 1'b1, 32'h0001_9B04});
    xfer(1'b1, 32'h0001_F800, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    check("R12 held", {95'd0, fail_vld, fail_addr}, {95'd0, 1'b1, 32'h0001_9B04});
    xfer(1'b1, addrs[1], pats[1] ^ 64'h1, enc(pats[1], addrs[1]));
    check("R12 single no capture", {95'd0, fail_vld, fail_addr}, {95'd0, 1'b1, 32'h0001_9B04});
    pulse_clr();
    check("R12 cleared", {95'd0, fail_vld, fail_addr}, 128'd0);
    // clear wins over a capture in the same cycle
    @(negedge clk);
    ecc_en = 1'b1; in_addr = 32'h0000_0100; in_data = '1; in_chk = 8'hFF; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; fail_clr = 1'b1;
    @(negedge clk);
    fail_clr = 1'b0;
    check("R12 clear wins", {95'd0, fail_vld, fail_addr}, 128'd0);
    check("R13 ded only", {126'd0, out_sec, out_ded}, {126'd0, 1'b0, 1'b1});
    xfer(1'b1, 32'h0000_0208, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    check("R12 recapture", {95'd0, fail_vld, fail_addr}, {95'd0, 1'b1, 32'h0000_0208});

    // R10: back-to-back latency
    @(negedge clk);
    ecc_en = 1'b1; in_addr = addrs[4]; in_data = pats[3]; in_chk = enc(pats[3], addrs[4]); in_vld = 1'b1;
    @(negedge clk);
    in_addr = addrs[5]; in_data = pats[4] ^ 64'h4; in_chk = enc(pats[4], addrs[5]);
    check("R10 not yet", {127'd0, out_vld}, 128'd0);
    @(negedge clk);
    in_vld = 1'b0;
    expect_out("R10 first", pats[3], 1'b0, 1'b0);
    @(negedge clk);
    expect_out("R10 second", pats[4], 1'b1, 1'b0);
    @(negedge clk);
    check("R10 drop", {125'd0, out_vld, out_sec, out_ded}, 128'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule